// File: doc/BRIEF.md
# Flash Status-Polling Word Generator

This block produces the status word that a parallel NOR flash returns on its data bus while an embedded program or erase runs. The surrounding device model gives it the current operation, the address being read, a per-block erasing mask, the data byte being programmed, an erase-timer flag and failure indications. The block returns either array data or a synthetic status byte. Its two toggle bits change state once for each completed read. It also drives an open-drain ready/busy line, shown as an enable and a driven value.

A failure or a buffer abort is latched. From then on the block keeps reporting that outcome, whatever the operation input does, until a read/reset command clears it. Host software polls the word and uses the toggle bits, the timeout bit and the abort bit to tell success from failure. On the reads that follow, the block tells an erasing block from a non-erasing block, and a faulty block from a good one.

Top module: `flash_poll_status`

## Requirements
- R1: After reset no failure is latched, both toggle bits are 0 and the ready/busy enable is 0. In read mode the data bus equals `array_i`. `rb_o` is always 0.
- R2: Operation codes on `op_i` are 0 read, 1 program, 2 buffered program, 3 chip erase, 4 block erase, 5 erase suspend; codes 6 and 7 act as read. In read mode with nothing latched, `dq_o` equals `array_i` and `rb_oe_o` is 0.
- R3: During program or buffered program, bit 7 is the inverse of `last_data_i[7]` and bit 6 is the DQ6 toggle. Bits 5, 3, 2 and 1 are 0 and `rb_oe_o` is 1. In every status word, bits 4 and 0 are 0.
- R4: A completed read is a rising edge of `oe_n_i`. The DQ6 toggle inverts after each completed read in program, erase or latched-failure states. It holds in read mode and in erase suspend.
- R5: During chip erase, bit 7 is 0, bit 6 toggles, bit 5 is 0, bit 3 is 1 and bit 2 (the DQ2 toggle) inverts after every completed read. `rb_oe_o` is 1.
- R6: During block erase, bit 3 equals `timer_done_i`. The DQ2 toggle advances only on reads whose block index (the top log2(NBLK) address bits) is set in `erasing_i`. Reads of other blocks return the held DQ2 value.
- R7: In erase suspend, reading a non-erasing block returns `array_i`. Reading an erasing block returns bit 7 = 1, bit 6 held and bit 2 toggling. `rb_oe_o` is 0 in both cases.
- R8: A `fault_i` pulse during program or buffered program latches a program failure. The status then reads bit 5 = 1, bit 7 = the inverse of `last_data_i[7]` as captured, and a toggling bit 6, with `rb_oe_o` = 1. This persists even if `op_i` changes.
- R9: An `abort_i` pulse during buffered program latches an abort. The status then reads bit 1 = 1, bit 5 = 0, a toggling bit 6 and bit 7 = the captured inverse data bit.
- R10: A `fault_i` pulse during chip or block erase latches an erase failure and captures `faulty_i`. The status then reads bit 7 = 0, bit 5 = 1 and bit 3 = 1, with bit 6 toggling. The DQ2 toggle advances only on reads of captured faulty blocks.
- R11: `rd_reset_i` clears a latched outcome on the next clock. A capture in the same cycle as `rd_reset_i` is dropped. A second capture while one is latched is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Current embedded operation code |
| rd_addr_i | input | AW | Address being read |
| oe_n_i | input | 1 | Active-low output enable; rising edge ends a read |
| erasing_i | input | NBLK | Blocks selected for erase |
| faulty_i | input | NBLK | Blocks that failed erase, captured on erase failure |
| last_data_i | input | 8 | Byte being programmed (last loaded for buffered program) |
| timer_done_i | input | 1 | Erase time-out window has expired |
| fault_i | input | 1 | One-cycle failure indication |
| abort_i | input | 1 | One-cycle buffer abort indication |
| rd_reset_i | input | 1 | Read/reset command strobe |
| array_i | input | 8 | Array data for the read address |
| dq_o | output | 8 | Returned data or status word |
| rb_oe_o | output | 1 | Ready/busy pull-down enable (0 = released) |
| rb_o | output | 1 | Value driven on ready/busy when enabled |

## Verification
The assertions assume three things about the inputs. `oe_n_i` starts high after reset, and each read holds `rd_addr_i` and `op_i` steady until its rising edge has been clocked. `fault_i`, `abort_i` and `rd_reset_i` arrive as single-cycle pulses, never two in one cycle except in the directed reset-versus-capture case. The stimulus changes operation, masks and data only between reads and issues every strobe through one read task, so both toggle bits step only at clocked strobe ends.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_PROG    = 3'd1,
        OP_BUFPROG = 3'd2,
        OP_CHIPER  = 3'd3,
        OP_BLKER   = 3'd4,
        OP_SUSP    = 3'd5,
        OP_RSV6    = 3'd6,
        OP_RSV7    = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        LT_NONE    = 2'd0,
        LT_PROGERR = 2'd1,
        LT_ABORT   = 2'd2,
        LT_ERASERR = 2'd3
    } latch_e;

    typedef struct packed {
        logic b7;
        logic b6;
        logic b5;
        logic b4;
        logic b3;
        logic b2;
        logic b1;
        logic b0;
    } stat_s;

    function automatic logic is_prog(op_e o);
        return (o == OP_PROG) || (o == OP_BUFPROG);
    endfunction

    function automatic logic is_erase(op_e o);
        return (o == OP_CHIPER) || (o == OP_BLKER);
    endfunction

endpackage

// File: rtl/fp_strobe.sv
module fp_strobe (
    input  logic clk,
    input  logic rst,
    input  logic oe_n_i,
    output logic rd_done_o
);
    logic oe_q;

    always_ff @(posedge clk) begin
        if (rst) oe_q <= 1'b1;
        else     oe_q <= oe_n_i;
    end

    assign rd_done_o = oe_n_i & ~oe_q;

    // R4: a completed read is a single-cycle event
    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        rd_done_o |=> !rd_done_o);
endmodule

// File: rtl/fp_latch.sv
module fp_latch
    import flash_poll_pkg::*;
#(
    parameter int NBLK = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  op_e             op_i,
    input  logic            fault_i,
    input  logic            abort_i,
    input  logic            rd_reset_i,
    input  logic            d7_i,
    input  logic [NBLK-1:0] faulty_i,
    output latch_e          kind_o,
    output logic            d7_o,
    output logic [NBLK-1:0] fmask_o
);
    latch_e          kind_q;
    logic            d7_q;
    logic [NBLK-1:0] fmask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= LT_NONE;
            d7_q    <= 1'b0;
            fmask_q <= '0;
        end else if (rd_reset_i) begin
            kind_q  <= LT_NONE;
        end else if (kind_q == LT_NONE) begin
            if (fault_i && is_prog(op_i)) begin
                kind_q <= LT_PROGERR;
                d7_q   <= d7_i;
            end else if (fault_i && is_erase(op_i)) begin
                kind_q  <= LT_ERASERR;
                fmask_q <= faulty_i;
            end else if (abort_i && op_i == OP_BUFPROG) begin
                kind_q <= LT_ABORT;
                d7_q   <= d7_i;
            end
        end
    end

    assign kind_o  = kind_q;
    assign d7_o    = d7_q;
    assign fmask_o = fmask_q;

    // R11: a latched outcome survives until read/reset
    p_latch_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (kind_q != LT_NONE && !rd_reset_i) |=> $stable(kind_q));
    // R11: read/reset always clears
    p_latch_clear_r11: assert property (@(posedge clk) disable iff (rst)
        rd_reset_i |=> kind_q == LT_NONE);
endmodule

// File: rtl/fp_toggle.sv
module fp_toggle (
    input  logic clk,
    input  logic rst,
    input  logic rd_done_i,
    input  logic adv6_i,
    input  logic adv2_i,
    output logic t6_o,
    output logic t2_o
);
    logic t6_q, t2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            t6_q <= 1'b0;
            t2_q <= 1'b0;
        end else if (rd_done_i) begin
            if (adv6_i) t6_q <= ~t6_q;
            if (adv2_i) t2_q <= ~t2_q;
        end
    end

    assign t6_o = t6_q;
    assign t2_o = t2_q;

    // R4: DQ6 steps exactly on a qualifying completed read
    p_t6_step_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_done_i && adv6_i) |=> t6_q != $past(t6_q));
    p_t6_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(rd_done_i && adv6_i) |=> $stable(t6_q));
    // R6: DQ2 holds unless a qualifying read completes
    p_t2_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(rd_done_i && adv2_i) |=> $stable(t2_q));
endmodule

// File: rtl/fp_status_mux.sv
module fp_status_mux
    import flash_poll_pkg::*;
(
    input  op_e        op_i,
    input  latch_e     kind_i,
    input  logic       blk_erasing_i,
    input  logic       blk_faulty_i,
    input  logic       t6_i,
    input  logic       t2_i,
    input  logic       d7_live_i,
    input  logic       d7_held_i,
    input  logic       timer_i,
    input  logic [7:0] array_i,
    output logic [7:0] dq_o,
    output logic       rb_oe_o,
    output logic       adv6_o,
    output logic       adv2_o
);
    stat_s st;
    logic  pass;

    always_comb begin
        st      = '0;
        pass    = 1'b0;
        rb_oe_o = 1'b0;
        adv6_o  = 1'b0;
        adv2_o  = 1'b0;
        if (kind_i != LT_NONE) begin
            rb_oe_o = 1'b1;
            adv6_o  = 1'b1;
            st.b6   = t6_i;
            case (kind_i)
                LT_PROGERR: begin
                    st.b7 = ~d7_held_i;
                    st.b5 = 1'b1;
                end
                LT_ABORT: begin
                    st.b7 = ~d7_held_i;
                    st.b1 = 1'b1;
                end
                default: begin
                    st.b5  = 1'b1;
                    st.b3  = 1'b1;
                    st.b2  = t2_i;
                    adv2_o = blk_faulty_i;
                end
            endcase
        end else begin
            case (op_i)
                OP_PROG, OP_BUFPROG: begin
                    st.b7   = ~d7_live_i;
                    st.b6   = t6_i;
                    rb_oe_o = 1'b1;
                    adv6_o  = 1'b1;
                end
                OP_CHIPER: begin
                    st.b6   = t6_i;
                    st.b3   = 1'b1;
                    st.b2   = t2_i;
                    rb_oe_o = 1'b1;
                    adv6_o  = 1'b1;
                    adv2_o  = 1'b1;
                end
                OP_BLKER: begin
                    st.b6   = t6_i;
                    st.b3   = timer_i;
                    st.b2   = t2_i;
                    rb_oe_o = 1'b1;
                    adv6_o  = 1'b1;
                    adv2_o  = blk_erasing_i;
                end
                OP_SUSP: begin
                    if (blk_erasing_i) begin
                        st.b7  = 1'b1;
                        st.b6  = t6_i;
                        st.b2  = t2_i;
                        adv2_o = 1'b1;
                    end else begin
                        pass = 1'b1;
                    end
                end
                default: pass = 1'b1;
            endcase
        end
        dq_o = pass ? array_i : st;
    end
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
    import flash_poll_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NBLK = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      op_i,
    input  logic [AW-1:0]   rd_addr_i,
    input  logic            oe_n_i,
    input  logic [NBLK-1:0] erasing_i,
    input  logic [NBLK-1:0] faulty_i,
    input  logic [7:0]      last_data_i,
    input  logic            timer_done_i,
    input  logic            fault_i,
    input  logic            abort_i,
    input  logic            rd_reset_i,
    input  logic [7:0]      array_i,
    output logic [7:0]      dq_o,
    output logic            rb_oe_o,
    output logic            rb_o
);
    localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1;

    op_e             op;
    latch_e          kind;
    logic            d7_held;
    logic [NBLK-1:0] fmask;
    logic            rd_done, adv6, adv2, t6, t2;
    logic [BLK_W-1:0] blk;

    assign op  = op_e'(op_i);
    assign blk = rd_addr_i[AW-1 -: BLK_W];

    fp_strobe u_strobe (
        .clk(clk), .rst(rst), .oe_n_i(oe_n_i), .rd_done_o(rd_done)
    );

    fp_latch #(.NBLK(NBLK)) u_latch (
        .clk(clk), .rst(rst), .op_i(op), .fault_i(fault_i),
        .abort_i(abort_i), .rd_reset_i(rd_reset_i),
        .d7_i(last_data_i[7]), .faulty_i(faulty_i),
        .kind_o(kind), .d7_o(d7_held), .fmask_o(fmask)
    );

    fp_toggle u_toggle (
        .clk(clk), .rst(rst), .rd_done_i(rd_done),
        .adv6_i(adv6), .adv2_i(adv2), .t6_o(t6), .t2_o(t2)
    );

    fp_status_mux u_mux (
        .op_i(op), .kind_i(kind),
        .blk_erasing_i(erasing_i[blk]), .blk_faulty_i(fmask[blk]),
        .t6_i(t6), .t2_i(t2), .d7_live_i(last_data_i[7]),
        .d7_held_i(d7_held), .timer_i(timer_done_i), .array_i(array_i),
        .dq_o(dq_o), .rb_oe_o(rb_oe_o), .adv6_o(adv6), .adv2_o(adv2)
    );

    assign rb_o = 1'b0;

    // R8: a failure bit on the bus keeps ready/busy pulled low
    p_fail_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (kind == LT_PROGERR) |-> (dq_o[5] && rb_oe_o));
    // R7: erase suspend releases ready/busy
    p_susp_release_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SUSP && kind == LT_NONE) |-> !rb_oe_o);
    // R2: read mode passes array data
    p_read_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_READ && kind == LT_NONE) |-> (dq_o == array_i && !rb_oe_o));
endmodule

// File: tb/flash_poll_status_test.sv
`timescale 1ns/1ps
module flash_poll_status_test;
    localparam int AW = 16;
    localparam int NBLK = 8;
    localparam int BW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] op = 3'd0;
    logic [AW-1:0] addr = '0;
    logic oe_n = 1'b1;
    logic [NBLK-1:0] erasing = '0, faulty = '0;
    logic [7:0] ldata = '0, arr = '0;
    logic timer = 1'b0, fault = 1'b0, abrt = 1'b0, rrst = 1'b0;
    logic [7:0] dq;
    logic rb_oe, rb;

    int total = 0, bad = 0;
    logic m_t6 = 1'b0, m_t2 = 1'b0, m_d7 = 1'b0;
    int m_kind = 0;
    logic [NBLK-1:0] m_fmask = '0;

    always #4 clk = ~clk;

    flash_poll_status #(.AW(AW), .NBLK(NBLK)) uut (
        .clk(clk), .rst(rst), .op_i(op), .rd_addr_i(addr), .oe_n_i(oe_n),
        .erasing_i(erasing), .faulty_i(faulty), .last_data_i(ldata),
        .timer_done_i(timer), .fault_i(fault), .abort_i(abrt),
        .rd_reset_i(rrst), .array_i(arr), .dq_o(dq), .rb_oe_o(rb_oe), .rb_o(rb)
    );

    // expected {adv6, adv2, rb_oe, dq}
    function automatic logic [10:0] expect_of(logic [AW-1:0] a);
        logic [7:0] d;
        logic e6, e2, r;
        int b;
        b = int'(a[AW-1 -: BW]);
        d = 8'h00; e6 = 0; e2 = 0; r = 0;
        if (m_kind == 1) begin
            d[7] = ~m_d7; d[6] = m_t6; d[5] = 1; r = 1; e6 = 1;
        end else if (m_kind == 2) begin
            d[7] = ~m_d7; d[6] = m_t6; d[1] = 1; r = 1; e6 = 1;
        end else if (m_kind == 3) begin
            d[6] = m_t6; d[5] = 1; d[3] = 1; d[2] = m_t2; r = 1; e6 = 1; e2 = m_fmask[b];
        end else if (op == 3'd1 || op == 3'd2) begin
            d[7] = ~ldata[7]; d[6] = m_t6; r = 1; e6 = 1;
        end else if (op == 3'd3) begin
            d[6] = m_t6; d[3] = 1; d[2] = m_t2; r = 1; e6 = 1; e2 = 1;
        end else if (op == 3'd4) begin
            d[6] = m_t6; d[3] = timer; d[2] = m_t2; r = 1; e6 = 1; e2 = erasing[b];
        end else if (op == 3'd5 && erasing[b]) begin
            d[7] = 1; d[6] = m_t6; d[2] = m_t2; e2 = 1;
        end else begin
            d = arr;
        end
        return {e6, e2, r, d};
    endfunction

    function automatic string tag_of();
        if (m_kind == 1) return "R8";
        if (m_kind == 2) return "R9";
        if (m_kind == 3) return "R10";
        case (op)
            3'd1, 3'd2: return "R3";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic check(string tag, logic [8:0] got, logic [8:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: rb_oe,dq actual=%b,%h expected=%b,%h",
                     tag, got[8], got[7:0], exp[8], exp[7:0]);
        end
    endtask

    task automatic do_read(logic [AW-1:0] a, string tag);
        logic [10:0] e;
        addr = a;
        oe_n = 1'b0;
        @(negedge clk);
        e = expect_of(a);
        check((tag == "") ? tag_of() : tag, {rb_oe, dq}, e[8:0]);
        oe_n = 1'b1;
        @(negedge clk);
        if (e[10]) m_t6 = ~m_t6;
        if (e[9])  m_t2 = ~m_t2;
    endtask

    task automatic pulse(logic f, logic ab, logic r);
        fault = f; abrt = ab; rrst = r;
        @(negedge clk);
        fault = 0; abrt = 0; rrst = 0;
        if (r) m_kind = 0;
        else if (m_kind == 0) begin
            if (f && (op == 3'd1 || op == 3'd2)) begin m_kind = 1; m_d7 = ldata[7]; end
            else if (f && (op == 3'd3 || op == 3'd4)) begin m_kind = 3; m_fmask = faulty; end
            else if (ab && op == 3'd2) begin m_kind = 2; m_d7 = ldata[7]; end
        end
    endtask

    initial begin
        #(8ns * 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] s1, s2;
        void'($urandom(32'd2024));
        arr = 8'h5A;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", {rb_oe, dq}, {1'b0, 8'h5A});
        total++;
        if (rb !== 1'b0) begin bad++; $display("FAIL R1: rb actual=%b expected=0", rb); end

        // R3 / R4: program, DQ6 flips between reads
        op = 3'd1; ldata = 8'h80;
        do_read(16'h0010, "R3"); s1 = dq;
        do_read(16'h0010, "R4");
        // R6: block erase, non-erasing block holds DQ2
        op = 3'd4; erasing = 8'b0000_0010; timer = 1'b1;
        do_read(16'h0000, "R6");
        do_read(16'h0000, "R6");
        do_read(16'h2000, "R6");
        do_read(16'h2000, "R6");
        // R7 / R4: suspend, DQ6 held, non-erasing passes array
        op = 3'd5;
        addr = 16'h2000; @(negedge clk); s1 = dq;
        do_read(16'h2000, "R7");
        addr = 16'h2000; @(negedge clk); s2 = dq;
        total++;
        if (s1[6] !== s2[6]) begin bad++; $display("FAIL R4: dq6 actual=%b expected=%b", s2[6], s1[6]); end
        do_read(16'hE000, "R7");
        // R10: erase failure captured with faulty mask
        op = 3'd3; faulty = 8'b1000_0000;
        pulse(1, 0, 0);
        op = 3'd0;
        do_read(16'hE000, "R10");
        do_read(16'hE000, "R10");
        do_read(16'h0000, "R10");
        // R11: second capture ignored, then read/reset clears
        op = 3'd1; pulse(1, 0, 0);
        do_read(16'h0000, "R11");
        pulse(0, 0, 1);
        op = 3'd0; do_read(16'h0000, "R11");
        // R11: capture dropped when read/reset in same cycle
        op = 3'd1; pulse(1, 0, 1);
        op = 3'd0; do_read(16'h0000, "R11");
        // R9: buffer abort
        op = 3'd2; ldata = 8'h00; pulse(0, 1, 0);
        ldata = 8'hFF; do_read(16'h0000, "R9");
        op = 3'd4; do_read(16'h0000, "R9");
        pulse(0, 0, 1);
        // R8: program failure persists across op change
        op = 3'd1; ldata = 8'h7F; pulse(1, 0, 0);
        op = 3'd5; ldata = 8'h80; do_read(16'h4000, "R8");
        pulse(0, 0, 1);

        // random phase
        for (int i = 0; i < 600; i++) begin
            int r;
            op      = 3'($urandom % 8);
            erasing = NBLK'($urandom);
            faulty  = NBLK'($urandom);
            ldata   = 8'($urandom);
            arr     = 8'($urandom);
            timer   = 1'($urandom);
            r = int'($urandom % 16);
            if (r == 0) pulse(1, 0, 0);
            else if (r == 1) pulse(0, 1, 0);
            else if (r < 4) pulse(0, 0, 1);
            for (int k = 0; k < 1 + int'($urandom % 3); k++)
                do_read(AW'($urandom), "");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule